// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog that sits behind a small register window of 64 byte addresses. Software programs two preload values and picks a prescaler mode. It then enables the timer. The down counter first runs through the first preload and then through the second. When the second stage ends, the block sets a sticky expiry flag. It can also raise a one-cycle reset request, which carries a cold/warm qualifier, and it can hold a timeout output high. Software keeps the system alive by strobing a reload, which restarts the count from the first preload.

Writes to the preload registers and to the reload/flag register are guarded by a two-byte key. A lock bit freezes the enable bit and the configuration. The lock bit and the expiry flag are cleared only by `por_n`. All other state is also cleared by `rst_n`, which is the reset the watchdog itself can cause.

The register port has no back-pressure. A write on `bus_wr` or a read on `bus_rd` is accepted on the clock edge where it is high. Read data appears on `bus_rdata` with `bus_rvalid` exactly one cycle later, and the master must take it then. The `tick` input is the timebase. Each cycle in which it is high counts as one tick.

Top module: `twostage_wdt`

## Requirements
- R1: A write to the first preload (0x00), the second preload (0x04) or the control byte (0x0D) takes effect only if it directly follows the key: a write of 0x80 and then a write of 0x86 to 0x0C. A guarded write that arrives without the key leaves the register unchanged.
- R2: The key arms exactly one following access. Any read or write placed between the two key bytes, or any second byte other than 0x86, sends the key back to idle. A second guarded write after the armed one is ignored.
- R3: Each preload holds CNT_W bits and reads back zero-extended. A keyed write of 1 to bit 0 of 0x0D loads the down counter from the first preload. The counter value is readable at 0x14.
- R4: Writing 1 to enable (bit 1 of 0x18) while it is 0 loads the first preload. Each counting step decrements the counter. A step at zero in the first stage loads the second preload. A step at zero in the second stage is the expiry. So expiry comes after (preload1+1)+(preload2+1) steps.
- R5: On expiry, bit 1 of 0x0D is set. If cfg bit 4 is 1, `reset_req` is high for exactly one cycle, and `reset_cold` then equals cfg bit 3. If cfg bit 5 is 1, `timeout_out` goes high and stays high until a reload, a disable or a reset. The configuration register is at 0x10.
- R6: The expiry flag survives `rst_n`. It is cleared by `por_n`, or by a keyed write with bit 1 of 0x0D set. An unkeyed write does not clear it.
- R7: Writing lock (bit 0 of 0x18) makes later writes to 0x10 and 0x18 have no effect. The lock survives `rst_n` and is cleared only by `por_n`.
- R8: With cfg bit 2 = 0, every tick is one counting step. With cfg bit 2 = 1, one step occurs per 2^PRE_LOG2 ticks.
- R9: If bit 2 of 0x18 (one-shot) is 1, the counter stops at zero after expiry and does not expire again until a reload. If that bit is 0, the counter restarts from the first preload.
- R10: Writing 0 to enable stops the counter, which keeps its value.
- R11: After `rst_n` or `por_n`, the preloads, the configuration, enable, one-shot, the counter and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| rst_n | input | 1 | System reset, active low; keeps lock and expiry flag |
| tick | input | 1 | Timebase tick, one per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| reset_req | output | 1 | One-cycle reset request on expiry |
| reset_cold | output | 1 | Cold-reset qualifier, valid with reset_req |
| timeout_out | output | 1 | Level timeout output |

## Verification
The bench builds the block with CNT_W=16 and PRE_LOG2=2. With CNT_W=16, a 32-bit preload write shows that the upper bits are dropped and read back as zero. With PRE_LOG2=2, the divided step lands on every fourth tick, so the slow prescaler mode can be checked in a handful of ticks. Preloads of 0 to 3 keep each full two-stage expiry, one-shot halt and restart within a few dozen cycles.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_STAGE1 = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAGE2 = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_KEY    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h0D;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 6'h18;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_ARMED} key_state_e;

  // Configuration byte fields, bits 5..2 of the register.
  typedef struct packed {
    logic out_en;
    logic rst_en;
    logic cold;
    logic slow;
  } cfg_t;
endpackage

// File: rtl/twostage_wdt_key.sv
module twostage_wdt_key
  import twostage_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              grant
);
  key_state_e st_q, st_d;
  logic key_wr;

  assign key_wr = wr && (addr == OFS_KEY);
  assign grant  = (st_q == KEY_ARMED) && wr;

  always_comb begin
    st_d = st_q;
    case (st_q)
      KEY_IDLE:  if (key_wr && wbyte == KEY_FIRST) st_d = KEY_HALF;
      KEY_HALF:  if (wr || rd) st_d = (key_wr && wbyte == KEY_SECOND) ? KEY_ARMED : KEY_IDLE;
      KEY_ARMED: if (wr || rd) st_d = KEY_IDLE;
      default:   st_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/twostage_wdt_regs.sv
module twostage_wdt_regs
  import twostage_wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              grant,
  input  logic              expire,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  pv1,
  output logic [CNT_W-1:0]  pv2,
  output cfg_t              cfg,
  output logic              enable,
  output logic              oneshot,
  output logic              lock,
  output logic              flag,
  output logic              reload,
  output logic              start,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic guarded_ctrl, cfg_wr, lock_wr, flag_clr;
  logic [DATA_W-1:0] rmux;

  assign guarded_ctrl = wr && grant && (addr == OFS_CTRL);
  assign reload       = guarded_ctrl && wdata[0];
  assign flag_clr     = guarded_ctrl && wdata[1];
  assign cfg_wr       = wr && !lock && (addr == OFS_CFG);
  assign lock_wr      = wr && !lock && (addr == OFS_LOCK);
  assign start        = lock_wr && wdata[1] && !enable;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      pv1     <= '0;
      pv2     <= '0;
      cfg     <= '0;
      enable  <= 1'b0;
      oneshot <= 1'b0;
    end else begin
      if (wr && grant && addr == OFS_STAGE1) pv1 <= wdata[CNT_W-1:0];
      if (wr && grant && addr == OFS_STAGE2) pv2 <= wdata[CNT_W-1:0];
      if (cfg_wr) cfg <= cfg_t'(wdata[5:2]);
      if (lock_wr) begin
        enable  <= wdata[1];
        oneshot <= wdata[2];
      end
    end
  end

  // Sticky state: only power-on clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (lock_wr && wdata[0]) lock <= 1'b1;
      if (expire)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    rmux = '0;
    case (addr)
      OFS_STAGE1: rmux = DATA_W'(pv1);
      OFS_STAGE2: rmux = DATA_W'(pv2);
      OFS_CTRL:   rmux = DATA_W'({flag, 1'b0});
      OFS_CFG:    rmux = DATA_W'({cfg, 2'b00});
      OFS_COUNT:  rmux = DATA_W'(cnt);
      OFS_LOCK:   rmux = DATA_W'({oneshot, enable, lock});
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/twostage_wdt_core.sv
module twostage_wdt_core
  import twostage_wdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             tick,
  input  cfg_t             cfg,
  input  logic             enable,
  input  logic             oneshot,
  input  logic             load,
  input  logic [CNT_W-1:0] pv1,
  input  logic [CNT_W-1:0] pv2,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             reset_req,
  output logic             reset_cold,
  output logic             timeout_out
);
  logic stage2_q, halted_q, pre_wrap, step;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)                     pre_q <= '0;
        else if (load)                      pre_q <= '0;
        else if (tick && enable && cfg.slow) pre_q <= pre_q + 1'b1;
      end
      assign pre_wrap = (pre_q == {PRE_LOG2{1'b1}});
    end else begin : g_nopre
      assign pre_wrap = 1'b1;
    end
  endgenerate

  assign step   = tick && enable && !halted_q && !load && (!cfg.slow || pre_wrap);
  assign expire = step && stage2_q && (cnt == '0);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cnt      <= '0;
      stage2_q <= 1'b0;
      halted_q <= 1'b0;
    end else if (load) begin
      cnt      <= pv1;
      stage2_q <= 1'b0;
      halted_q <= 1'b0;
    end else if (step) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (!stage2_q) begin
        cnt      <= pv2;
        stage2_q <= 1'b1;
      end else begin
        stage2_q <= 1'b0;
        cnt      <= oneshot ? '0 : pv1;
        halted_q <= oneshot;
      end
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      reset_req   <= 1'b0;
      reset_cold  <= 1'b0;
      timeout_out <= 1'b0;
    end else begin
      reset_req  <= expire && cfg.rst_en;
      reset_cold <= expire && cfg.rst_en && cfg.cold;
      if (expire && cfg.out_en)  timeout_out <= 1'b1;
      else if (load || !enable)  timeout_out <= 1'b0;
    end
  end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              reset_req,
  output logic              reset_cold,
  output logic              timeout_out
);
  logic sys_rst_n, grant, expire, enable, oneshot, lock, flag, reload, start, load;
  logic [CNT_W-1:0] pv1, pv2, cnt;
  cfg_t cfg;

  assign sys_rst_n = rst_n && por_n;
  assign load      = reload || start;

  twostage_wdt_key u_key (
    .clk(clk), .rst_n(sys_rst_n), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wbyte(bus_wdata[7:0]), .grant(grant)
  );

  twostage_wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .grant(grant), .expire(expire), .cnt(cnt),
    .pv1(pv1), .pv2(pv2), .cfg(cfg), .enable(enable), .oneshot(oneshot),
    .lock(lock), .flag(flag), .reload(reload), .start(start),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  twostage_wdt_core #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2)) u_core (
    .clk(clk), .sys_rst_n(sys_rst_n), .tick(tick), .cfg(cfg),
    .enable(enable), .oneshot(oneshot), .load(load), .pv1(pv1), .pv2(pv2),
    .cnt(cnt), .expire(expire), .reset_req(reset_req),
    .reset_cold(reset_cold), .timeout_out(timeout_out)
  );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             reset_req,
  input logic             expire,
  input logic             flag,
  input logic             lock,
  input logic             enable,
  input logic             load,
  input logic [CNT_W-1:0] cnt
);
  // R5
  reset_req_pulse_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    reset_req |=> !reset_req);

  // R5
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expire |=> flag);

  // R6
  flag_only_on_expiry_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!flag && !expire) |=> !flag);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock |=> lock);

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!enable && !load) |=> $stable(cnt));

  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (enable && !load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
endmodule

bind twostage_wdt twostage_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .reset_req(reset_req),
  .expire(expire), .flag(flag), .lock(lock), .enable(enable),
  .load(load), .cnt(cnt)
);

// File: tb/twostage_wdt_tb.sv
module twostage_wdt_tb;
  localparam int CNT_W = 16;
  localparam int PRE_LOG2 = 2;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, reset_req, reset_cold, timeout_out;

  int total = 0, bad = 0, rr_pulses = 0;
  logic rr_seen, cold_seen;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  twostage_wdt #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .reset_req(reset_req),
    .reset_cold(reset_cold), .timeout_out(timeout_out)
  );

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk) begin
    if (reset_req) rr_pulses++;
    if (bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read: actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(6'h0C, 32'h80);
    wr(6'h0C, 32'h86);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      rr_seen = reset_req;
      cold_seen = reset_cold;
    end
  endtask

  task automatic pulse_rst(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    // R11 reset state
    chk({reset_req, reset_cold, timeout_out}, 0, "R11 outputs");
    rd(6'h00, 0, "R11 pv1"); rd(6'h10, 0, "R11 cfg");
    rd(6'h14, 0, "R11 count"); rd(6'h18, 0, "R11 lock");
    // R1 unkeyed write ignored, keyed write lands; R3 truncation
    wr(6'h00, 32'h5);
    rd(6'h00, 0, "R1 unkeyed pv1");
    unlock(); wr(6'h00, 32'h0001_0003);
    rd(6'h00, 32'h3, "R1 R3 keyed pv1 zero-extended");
    // R2 intervening read breaks the key
    wr(6'h0C, 32'h80); rd(6'h00, 32'h3, "R2 filler read");
    wr(6'h0C, 32'h86); wr(6'h04, 32'h9);
    rd(6'h04, 0, "R2 broken key");
    // R2 one write per key
    unlock(); wr(6'h04, 32'h2); wr(6'h00, 32'h7);
    rd(6'h04, 32'h2, "R2 armed write"); rd(6'h00, 32'h3, "R2 second write");
    // R2 wrong second byte
    wr(6'h0C, 32'h80); wr(6'h0C, 32'h85); wr(6'h0C, 32'h86); wr(6'h04, 32'h5);
    rd(6'h04, 32'h2, "R2 wrong byte");
    // R3 reload
    unlock(); wr(6'h0D, 32'h1);
    rd(6'h14, 32'h3, "R3 reload count");
    // R4 two stages, R5 expiry effects
    wr(6'h10, 32'h38); wr(6'h18, 32'h2);
    rd(6'h14, 32'h3, "R4 start load");
    ticks(3); rd(6'h14, 32'h0, "R4 stage1 end");
    ticks(1); rd(6'h14, 32'h2, "R4 stage2 load");
    ticks(2); chk(rr_seen, 0, "R4 no early expiry");
    ticks(1);
    chk(rr_seen, 1, "R5 reset_req"); chk(cold_seen, 1, "R5 reset_cold");
    chk(timeout_out, 1, "R5 timeout_out");
    rd(6'h0D, 32'h2, "R5 flag");
    rd(6'h14, 32'h3, "R9 restart from pv1");
    chk(rr_pulses, 1, "R5 single pulse");
    unlock(); wr(6'h0D, 32'h1);
    chk(timeout_out, 0, "R5 cleared by reload");
    // R6 flag survives rst_n; R11 rest cleared
    pulse_rst(0);
    rd(6'h0D, 32'h2, "R6 flag kept"); rd(6'h00, 0, "R11 pv1 after rst");
    rd(6'h18, 0, "R11 lock reg after rst"); rd(6'h14, 0, "R11 count after rst");
    wr(6'h0D, 32'h2); rd(6'h0D, 32'h2, "R6 unkeyed clear ignored");
    unlock(); wr(6'h0D, 32'h2); rd(6'h0D, 32'h0, "R6 keyed clear");
    // R8 slow prescaler, R10 disable holds
    unlock(); wr(6'h00, 32'h1);
    wr(6'h10, 32'h04); wr(6'h18, 32'h2);
    ticks(3); rd(6'h14, 32'h1, "R8 no step before 4 ticks");
    wr(6'h18, 32'h0); ticks(8);
    rd(6'h14, 32'h1, "R10 held while disabled");
    wr(6'h18, 32'h2); ticks(3);
    rd(6'h14, 32'h1, "R8 three ticks");
    ticks(1); rd(6'h14, 32'h0, "R8 fourth tick steps");
    // R9 one-shot halt
    wr(6'h18, 32'h0); wr(6'h10, 32'h30);
    unlock(); wr(6'h00, 32'h0); unlock(); wr(6'h04, 32'h0);
    rr_pulses = 0;
    wr(6'h18, 32'h6); ticks(2);
    chk(rr_seen, 1, "R9 expiry"); ticks(6);
    chk(rr_pulses, 1, "R9 no repeat after one-shot");
    chk(timeout_out, 1, "R9 output held");
    // R7 lock
    unlock(); wr(6'h0D, 32'h1);
    wr(6'h18, 32'h3); rd(6'h18, 32'h3, "R7 lock set");
    wr(6'h18, 32'h0); rd(6'h18, 32'h3, "R7 lock reg frozen");
    wr(6'h10, 32'h0); rd(6'h10, 32'h30, "R7 cfg frozen");
    pulse_rst(0);
    rd(6'h18, 32'h1, "R7 lock survives rst_n");
    wr(6'h18, 32'h2); rd(6'h18, 32'h1, "R7 still frozen");
    pulse_rst(1);
    rd(6'h18, 32'h0, "R7 por clears lock");
    rd(6'h0D, 32'h0, "R6 por clears flag");
    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R3 all reads answered");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule